// File: doc/BRIEF.md
# Page-Mode Asynchronous DRAM Controller

This block sits between a simple word-addressed host port and an asynchronous DRAM whose row and column addresses share one set of pins. Each host word address is split in two. The upper half selects the row and goes out while the row strobe falls. The lower half selects the column and goes out while the column strobe falls. Both strobes are active low. After an access the row stays open. A later request to the same row then needs only a column cycle. A request to another row first raises the row strobe for a precharge interval.

An internal timer raises a refresh request at a fixed interval. When the current access has finished, the pending refresh wins over any new host request. The controller closes the open row if there is one. It then lowers the column strobe before the row strobe, so the device picks the row to refresh from its own counter. All strobe widths and gaps are parameters counted in clock cycles. Read data is sampled a fixed number of cycles after the column strobe falls and is presented with a one-cycle valid pulse.

Top module: `dram_ctl`

## Requirements
- R1: While reset is held and on the first cycle after it, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are 1, and `rd_valid` and `dram_dq_oe` are 0.
- R2: Bits [2*ADDR_W-1:ADDR_W] of `req_addr` are the row and bits [ADDR_W-1:0] are the column. The row is on `dram_addr` in the cycle before `dram_ras_n` falls and on the falling cycle itself. The column is on `dram_addr` in the cycle before `dram_cas_n` falls and on the falling cycle itself.
- R3: A read returns the word most recently written to the same host address.
- R4: A request whose row equals the open row keeps `dram_ras_n` low and issues only a column cycle. For a read, `rd_valid` rises 1+T_CAS edges after the accepting edge.
- R5: A request to another row while a row is open holds `dram_ras_n` high for T_RP cycles and then opens the new row. For a read, `rd_valid` rises T_RP+T_RCD+1+T_CAS edges after acceptance.
- R6: With no row open, a read raises `rd_valid` 2+T_RCD+T_CAS edges after acceptance.
- R7: A refresh lowers `dram_cas_n` at least one cycle before `dram_ras_n`, keeps `dram_we_n` high, and happens once per REF_INTERVAL cycles on average.
- R8: A pending refresh takes priority over host requests (`req_ready` is 0). It starts with no row open, and the row strobe falls on the cycle after the column strobe falls. The first access after a refresh is a closed-row access.
- R9: `rd_valid` is a single-cycle pulse, given exactly once per accepted read and never for a write.
- R10: On a write, `dram_we_n` is low in the cycle before `dram_cas_n` falls. While `dram_cas_n` stays low, `dram_we_n` and `dram_dq_out` do not change and `dram_dq_oe` is 1.
- R11: `req_ready` is 1 only while no access or refresh is in progress. It is 0 in the cycle after a request is accepted, and `dram_cas_n` is high whenever `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2*ADDR_W | Word address, row in the upper half |
| req_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data |
| rd_valid | output | 1 | One-cycle pulse marking `rd_data` |
| dram_addr | output | ADDR_W | Shared row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | DATA_W | Data driven to the device |
| dram_dq_oe | output | 1 | Data output enable |
| dram_dq_in | input | DATA_W | Data returned by the device |

## Verification
The assertions assume that the host changes `req_addr`, `req_write` and `req_wdata` only while a request is being offered. They also assume that the device returns stable data on `dram_dq_in` from the cycle after the column strobe falls until the sampling edge, which requires T_CAS of at least 2. The bench holds each request until the edge that accepts it and then drops `req_valid`. Its device model latches the row and column on the strobe edges and drives the addressed word as soon as the column is latched. Random traffic is confined to a few rows so that page hits, row misses and refresh-interrupted sequences all occur.

// File: rtl/dram_ctl_pkg.sv
package dram_ctl_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PRE,
      ST_ROW,
      ST_ACT,
      ST_COL,
      ST_CAS,
      ST_CP,
      ST_RF_CLOSE,
      ST_RF_CAS,
      ST_RF_RAS,
      ST_RF_END
   } ctl_state_t;
endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
   parameter int INTERVAL = 780
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ack,
   output logic pending
);
   localparam int TW = $clog2(INTERVAL);
   localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

   logic [TW-1:0] tick;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tick    <= '0;
         pending <= 1'b0;
      end else begin
         tick <= (tick == LAST) ? '0 : tick + 1'b1;
         if (tick == LAST)
            pending <= 1'b1;
         else if (ack)
            pending <= 1'b0;
      end
   end
endmodule

// File: rtl/dram_open_row.sv
module dram_open_row #(
   parameter int ROW_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open_en,
   input  logic             close_en,
   input  logic [ROW_W-1:0] open_row,
   input  logic [ROW_W-1:0] probe_row,
   output logic             is_open,
   output logic             hit
);
   logic [ROW_W-1:0] cur_row;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         is_open <= 1'b0;
         cur_row <= '0;
      end else if (close_en) begin
         is_open <= 1'b0;
      end else if (open_en) begin
         is_open <= 1'b1;
         cur_row <= open_row;
      end
   end

   assign hit = is_open && (cur_row == probe_row);
endmodule

// File: rtl/dram_ctl.sv
module dram_ctl
   import dram_ctl_pkg::*;
#(
   parameter int ADDR_W       = 10,
   parameter int DATA_W       = 16,
   parameter int T_RP         = 3,
   parameter int T_RCD        = 2,
   parameter int T_CAS        = 3,
   parameter int T_CP         = 1,
   parameter int T_RAS_REF    = 4,
   parameter int REF_INTERVAL = 780
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic                  req_write,
   input  logic [2*ADDR_W-1:0]   req_addr,
   input  logic [DATA_W-1:0]     req_wdata,
   output logic [DATA_W-1:0]     rd_data,
   output logic                  rd_valid,
   output logic [ADDR_W-1:0]     dram_addr,
   output logic                  dram_ras_n,
   output logic                  dram_cas_n,
   output logic                  dram_we_n,
   output logic [DATA_W-1:0]     dram_dq_out,
   output logic                  dram_dq_oe,
   input  logic [DATA_W-1:0]     dram_dq_in
);
   localparam int HADDR_W = 2 * ADDR_W;
   localparam int M1   = (T_RP > T_RCD) ? T_RP : T_RCD;
   localparam int M2   = (T_CAS > T_CP) ? T_CAS : T_CP;
   localparam int M3   = (M1 > M2) ? M1 : M2;
   localparam int MAXT = (M3 > T_RAS_REF) ? M3 : T_RAS_REF;
   localparam int CNT_W = $clog2(MAXT + 1);

   // elaboration-time parameter checks
   if (ADDR_W < 1) begin : g_bad_addr
      $error("dram_ctl: ADDR_W must be at least 1");
   end
   if (T_CAS < 2) begin : g_bad_cas
      $error("dram_ctl: T_CAS must be at least 2");
   end
   if (T_RP < 1 || T_RCD < 1 || T_CP < 1 || T_RAS_REF < 1) begin : g_bad_tim
      $error("dram_ctl: timing counts must be at least 1");
   end
   if (REF_INTERVAL < 4 * MAXT + 8) begin : g_bad_ref
      $error("dram_ctl: REF_INTERVAL too short for the strobe timings");
   end

   ctl_state_t        state, nxt;
   logic [CNT_W-1:0]  cnt;
   logic              done;
   logic [ADDR_W-1:0] lat_row, lat_col;
   logic              lat_wr;
   logic [DATA_W-1:0] lat_wdata;
   logic              ref_pend, ref_ack;
   logic              row_is_open, row_hit;
   logic              accept;

   function automatic logic [CNT_W-1:0] dur(input ctl_state_t s);
      case (s)
         ST_PRE, ST_RF_CLOSE, ST_RF_END: dur = CNT_W'(T_RP - 1);
         ST_ACT:                         dur = CNT_W'(T_RCD - 1);
         ST_CAS:                         dur = CNT_W'(T_CAS - 1);
         ST_CP:                          dur = CNT_W'(T_CP - 1);
         ST_RF_RAS:                      dur = CNT_W'(T_RAS_REF - 1);
         default:                        dur = '0;
      endcase
   endfunction

   dram_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .ack     (ref_ack),
      .pending (ref_pend)
   );

   dram_open_row #(.ROW_W(ADDR_W)) u_rows (
      .clk       (clk),
      .rst_n     (rst_n),
      .open_en   (state == ST_ACT),
      .close_en  (state == ST_PRE || state == ST_RF_CLOSE || state == ST_RF_CAS),
      .open_row  (lat_row),
      .probe_row (req_addr[HADDR_W-1:ADDR_W]),
      .is_open   (row_is_open),
      .hit       (row_hit)
   );

   assign done      = (cnt == '0);
   assign req_ready = (state == ST_IDLE) && !ref_pend;
   assign accept    = req_valid && req_ready;
   assign ref_ack   = (state == ST_RF_CAS);

   always_comb begin
      nxt = state;
      case (state)
         ST_IDLE: begin
            if (ref_pend)
               nxt = row_is_open ? ST_RF_CLOSE : ST_RF_CAS;
            else if (req_valid)
               nxt = row_hit ? ST_COL : (row_is_open ? ST_PRE : ST_ROW);
         end
         ST_PRE:      if (done) nxt = ST_ACT;
         ST_ROW:      nxt = ST_ACT;
         ST_ACT:      if (done) nxt = ST_COL;
         ST_COL:      nxt = ST_CAS;
         ST_CAS:      if (done) nxt = ST_CP;
         ST_CP:       if (done) nxt = ST_IDLE;
         ST_RF_CLOSE: if (done) nxt = ST_RF_CAS;
         ST_RF_CAS:   nxt = ST_RF_RAS;
         ST_RF_RAS:   if (done) nxt = ST_RF_END;
         ST_RF_END:   if (done) nxt = ST_IDLE;
         default:     nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         lat_row   <= '0;
         lat_col   <= '0;
         lat_wr    <= 1'b0;
         lat_wdata <= '0;
         rd_data   <= '0;
         rd_valid  <= 1'b0;
      end else begin
         state <= nxt;
         if (nxt != state)
            cnt <= dur(nxt);
         else if (!done)
            cnt <= cnt - 1'b1;
         if (accept) begin
            lat_row   <= req_addr[HADDR_W-1:ADDR_W];
            lat_col   <= req_addr[ADDR_W-1:0];
            lat_wr    <= req_write;
            lat_wdata <= req_wdata;
         end
         rd_valid <= (state == ST_CAS) && done && !lat_wr;
         if ((state == ST_CAS) && done && !lat_wr)
            rd_data <= dram_dq_in;
      end
   end

   always_comb begin
      dram_ras_n = !((state == ST_ACT) || (state == ST_COL) || (state == ST_CAS) ||
                     (state == ST_CP) || (state == ST_RF_RAS) ||
                     ((state == ST_IDLE) && row_is_open));
      dram_cas_n = !((state == ST_CAS) || (state == ST_RF_CAS) || (state == ST_RF_RAS));
      dram_dq_oe = lat_wr && ((state == ST_COL) || (state == ST_CAS));
      dram_we_n  = !dram_dq_oe;
      dram_addr  = ((state == ST_PRE) || (state == ST_ROW) || (state == ST_ACT)) ? lat_row : lat_col;
   end

   assign dram_dq_out = lat_wdata;
endmodule

// File: rtl/dram_ctl_chk.sv
module dram_ctl_chk #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rd_valid,
   input logic [ADDR_W-1:0] dram_addr,
   input logic              dram_ras_n,
   input logic              dram_cas_n,
   input logic              dram_we_n,
   input logic [DATA_W-1:0] dram_dq_out
);
   // R7
   cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(dram_ras_n) && !dram_cas_n) |-> ($past(!dram_cas_n) && dram_we_n));

   // R8
   ref_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(dram_cas_n) && dram_ras_n) |=> !dram_ras_n);

   // R2
   row_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(dram_ras_n) && dram_cas_n) |-> $stable(dram_addr));

   // R2
   col_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(dram_cas_n) && !dram_ras_n) |-> $stable(dram_addr));

   // R10
   we_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(dram_cas_n) && !dram_ras_n && !dram_we_n) |-> $past(!dram_we_n));

   // R10
   wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!dram_cas_n && $past(!dram_cas_n) && !dram_ras_n && $past(!dram_ras_n))
         |-> ($stable(dram_we_n) && $stable(dram_dq_out)));

   // R9
   rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

   // R11
   ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> dram_cas_n);
endmodule

bind dram_ctl dram_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_ready   (req_ready),
   .rd_valid    (rd_valid),
   .dram_addr   (dram_addr),
   .dram_ras_n  (dram_ras_n),
   .dram_cas_n  (dram_cas_n),
   .dram_we_n   (dram_we_n),
   .dram_dq_out (dram_dq_out)
);

// File: tb/sim_dram_ctl.sv
`timescale 1ns/1ps
module sim_dram_ctl;
   localparam int AW = 4;
   localparam int DW = 8;
   localparam int TRP = 3, TRCD = 2, TCAS = 3, TCP = 2, TRF = 4, RINT = 300;
   localparam int DEPTH = 1 << (2 * AW);
   localparam int LAT_HIT  = 1 + TCAS;
   localparam int LAT_CLS  = 2 + TRCD + TCAS;
   localparam int LAT_MISS = TRP + TRCD + 1 + TCAS;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [2*AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic req_ready, rd_valid, dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
   logic [DW-1:0] rd_data, dram_dq_out, dram_dq_in;
   logic [AW-1:0] dram_addr;

   always #2.5 clk = ~clk;

   dram_ctl #(.ADDR_W(AW), .DATA_W(DW), .T_RP(TRP), .T_RCD(TRCD), .T_CAS(TCAS),
              .T_CP(TCP), .T_RAS_REF(TRF), .REF_INTERVAL(RINT)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_data(rd_data), .rd_valid(rd_valid), .dram_addr(dram_addr),
      .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
      .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in));

   // device model and host-side shadow copy
   logic [DW-1:0] mem [DEPTH];
   logic [DW-1:0] shadow [DEPTH];
   logic [AW-1:0] m_row = '0, m_col = '0;
   logic prev_ras = 1'b1, prev_cas = 1'b1;
   int ref_cnt = 0, act_cnt = 0, cbr_bad = 0, oe_bad = 0, rv_cnt = 0, cyc = 0;
   int n_chk = 0, n_err = 0;

   function automatic logic [DW-1:0] pat(input int a);
      return DW'(a * 13 + 5);
   endfunction

   initial begin
      for (int i = 0; i < DEPTH; i++) begin
         mem[i]    = pat(i);
         shadow[i] = pat(i);
      end
   end

   assign dram_dq_in = mem[{m_row, m_col}];

   always @(posedge clk) begin
      if (!rst_n) begin
         prev_ras <= 1'b1;
         prev_cas <= 1'b1;
      end else begin
         cyc <= cyc + 1;
         if (rd_valid) rv_cnt <= rv_cnt + 1;
         if (prev_ras && !dram_ras_n) begin
            if (!dram_cas_n) begin
               ref_cnt <= ref_cnt + 1;
               if (prev_cas || !dram_we_n) cbr_bad <= cbr_bad + 1;
            end else begin
               m_row   <= dram_addr;
               act_cnt <= act_cnt + 1;
            end
         end
         if (prev_cas && !dram_cas_n && !dram_ras_n) begin
            m_col <= dram_addr;
            if (!dram_we_n) begin
               if (!dram_dq_oe) oe_bad <= oe_bad + 1;
               mem[{m_row, dram_addr}] <= dram_dq_out;
            end
         end
         prev_ras <= dram_ras_n;
         prev_cas <= dram_cas_n;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic summary;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
   endtask

   task automatic issue(input bit wr, input logic [2*AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = a;
      req_wdata = d;
      @(posedge clk);
      #1 req_valid = 1'b0;
      @(negedge clk);
      check(req_ready == 1'b0, "R11 ready after accept", int'(req_ready), 0);
      if (wr) shadow[a] = d;
   endtask

   task automatic do_read(input logic [2*AW-1:0] a, output logic [DW-1:0] d, output int lat);
      int n;
      issue(1'b0, a, '0);
      n = 1;
      while (!rd_valid && n < 200) begin
         @(negedge clk);
         n++;
      end
      lat = n - 1;
      d = rd_data;
      @(negedge clk);
      check(rd_valid == 1'b0, "R9 single pulse", int'(rd_valid), 0);
   endtask

   initial begin
      #750000;
      n_err++;
      n_chk++;
      $display("FAIL R11 watchdog actual %0d expected %0d", 0, 1);
      summary();
      $finish;
   end

   initial begin
      logic [DW-1:0] d;
      int lat, a0, nrd, r0;
      void'($urandom(32'd4242));
      repeat (4) @(negedge clk);
      check(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes in reset", int'({dram_ras_n, dram_cas_n, dram_we_n}), 7);
      rst_n = 1'b1;
      @(negedge clk);
      check(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes after reset", int'({dram_ras_n, dram_cas_n, dram_we_n}), 7);
      check(!rd_valid && !dram_dq_oe, "R1 valid/oe after reset", int'({rd_valid, dram_dq_oe}), 0);

      // directed: wait for the first refresh, then closed / hit / miss
      while (ref_cnt == 0) @(negedge clk);
      check(ref_cnt == 1, "R7 first refresh", ref_cnt, 1);
      a0 = act_cnt;
      do_read({4'd3, 4'd0}, d, lat);
      check(lat == LAT_CLS, "R6 R8 closed-row latency", lat, LAT_CLS);
      check(d == pat(8'h30), "R3 read initial word", int'(d), int'(pat(8'h30)));
      check(act_cnt == a0 + 1, "R6 one activation", act_cnt, a0 + 1);
      issue(1'b1, {4'd3, 4'd4}, 8'hA5);
      do_read({4'd3, 4'd4}, d, lat);
      check(lat == LAT_HIT, "R4 page hit latency", lat, LAT_HIT);
      check(d == 8'hA5, "R3 read after write", int'(d), 'hA5);
      check(act_cnt == a0 + 1, "R4 no new activation", act_cnt, a0 + 1);
      check(mem[8'h34] == 8'hA5, "R2 row/col placement", int'(mem[8'h34]), 'hA5);
      do_read({4'd6, 4'd1}, d, lat);
      check(lat == LAT_MISS, "R5 row miss latency", lat, LAT_MISS);
      check(d == pat(8'h61), "R3 miss data", int'(d), int'(pat(8'h61)));
      check(act_cnt == a0 + 2, "R5 new activation", act_cnt, a0 + 2);
      nrd = 3;
      r0 = rv_cnt;

      // random traffic over a few rows
      for (int k = 0; k < 600; k++) begin
         logic [2*AW-1:0] a;
         bit wr;
         a  = {AW'($urandom % 4), AW'($urandom % (1 << AW))};
         wr = ($urandom % 3) == 0;
         if (wr) begin
            issue(1'b1, a, DW'($urandom));
         end else begin
            do_read(a, d, lat);
            nrd++;
            check(d == shadow[a], "R3 random read", int'(d), int'(shadow[a]));
         end
         repeat ($urandom % 3) @(negedge clk);
      end
      repeat (20) @(negedge clk);
      check(rv_cnt - r0 == nrd - 3, "R9 pulses per read", rv_cnt - r0, nrd - 3);
      check(cbr_bad == 0, "R7 CAS before RAS", cbr_bad, 0);
      check(oe_bad == 0, "R10 data enable on write", oe_bad, 0);
      check((ref_cnt - cyc / RINT) <= 1 && (cyc / RINT - ref_cnt) <= 1,
            "R7 refresh rate", ref_cnt, cyc / RINT);
      summary();
      $finish;
   end
endmodule